// File: doc/BRIEF.md
# Processor Interrupt Level Resolver

This block turns a set of pending interrupt sources into one hardware interrupt request and a trap type for a processor core. It merges sixteen external level inputs with a software-interrupt register. Two timer-match flags in that register are treated as level 14. It then selects the highest pending level above the core's current interrupt level and presents the matching trap type.

It re-evaluates every clock and registers its two outputs. A pending vector interrupt outranks every level interrupt, so while one is pending the outputs are frozen. A nested external trap of lower priority is held back while the core is already servicing a higher external trap.

Top module: `irq_level_resolver`

## Requirements
- R1: Reset drives `irq_req` to 0 and `irq_tt` to 0.
- R2: The effective pending vector is `ext_lvl` ORed with `soft_int`, where `soft_int` bits 0 and 15 (the timer-match flags) are excluded from the OR. A set bit 15 in `soft_int` therefore never selects level 15.
- R3: When `soft_int` bit 0 or bit 15 is set, level 14 is pending.
- R4: While `vec_pend` is 1, both outputs keep their previous values on the next clock.
- R5: When `vec_pend` is 0 and the effective vector, read as an unsigned number, is below 2 shifted left by `cur_pil`, the next clock gives `irq_req` = 0 and `irq_tt` = 0. A value equal to that bound is not below it.
- R6: When `vec_pend` is 0, `int_en` is 1 and the bound in R5 is met, the candidate is the highest set level i with i > `cur_pil`. Its trap type is 0x040 | i. If that differs from `irq_tt`, the next clock gives `irq_tt` = candidate and `irq_req` = 1.
- R7: The candidate of R6 is not taken, and both outputs hold, when `trap_lvl` > 0, (`tt_busy` & 0x1F0) == 0x040 and `tt_busy` > candidate.
- R8: When the candidate equals the current `irq_tt`, both outputs hold.
- R9: When `vec_pend` is 0, `int_en` is 0 and the bound in R5 is met, an active request is withdrawn with `irq_tt` = 0 on the next clock. With no active request, both outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_lvl | input | 16 | External pending levels, bit i = level i |
| soft_int | input | 16 | Software interrupt register; bits 0 and 15 are timer-match flags |
| cur_pil | input | 4 | Current processor interrupt level |
| int_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap level |
| tt_busy | input | 9 | Trap type of the trap in service |
| vec_pend | input | 1 | Vector interrupt pending |
| irq_req | output | 1 | Hardware interrupt request |
| irq_tt | output | 9 | Selected trap type |

## Verification
A wrong merge or threshold shows up one clock after the inputs settle: the trap type is off, or a request appears or vanishes when it should not. A broken hold path, under a pending vector or for a suppressed nested trap, shows as an output that moves on the first clock it should have kept still. Two cases separate a correct mask from a missing one: software bit 15 with only low levels pending, and a timer flag alone. Each is checked within one cycle.

// File: rtl/irq_level_resolver.sv
module irq_level_resolver #(
  parameter int LVLS = 16,
  parameter int PIL_W = 4,
  parameter int TL_W = 3,
  parameter int TT_W = 9,
  parameter logic [TT_W-1:0] EXT_BASE = 9'h040,
  parameter logic [TT_W-1:0] GRP_MASK = 9'h1F0,
  parameter int TMR_A = 0,
  parameter int TMR_B = 15,
  parameter int TMR_LVL = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVLS-1:0]  ext_lvl,
  input  logic [LVLS-1:0]  soft_int,
  input  logic [PIL_W-1:0] cur_pil,
  input  logic             int_en,
  input  logic [TL_W-1:0]  trap_lvl,
  input  logic [TT_W-1:0]  tt_busy,
  input  logic             vec_pend,
  output logic             irq_req,
  output logic [TT_W-1:0]  irq_tt
);
  localparam logic [LVLS-1:0] TMR_MASK = (LVLS'(1) << TMR_A) | (LVLS'(1) << TMR_B);

  logic [LVLS-1:0] eff;
  logic            below;
  logic [TT_W-1:0] cand;
  logic            nested_block;

  assign eff = ext_lvl | (soft_int & ~TMR_MASK)
             | ((|(soft_int & TMR_MASK)) ? (LVLS'(1) << TMR_LVL) : '0);
  assign below = {1'b0, eff} < ((LVLS+1)'(2) << cur_pil);

  always_comb begin
    cand = '0;
    for (int i = 1; i < LVLS; i++)
      if (eff[i] && (i > int'(cur_pil)))
        cand = EXT_BASE | TT_W'(i);
  end

  assign nested_block = (trap_lvl != '0) && ((tt_busy & GRP_MASK) == EXT_BASE)
                      && (tt_busy > cand);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_tt  <= '0;
    end else if (!vec_pend) begin
      if (below) begin
        irq_req <= 1'b0;
        irq_tt  <= '0;
      end else if (int_en) begin
        if (!nested_block && (cand != irq_tt)) begin
          irq_req <= 1'b1;
          irq_tt  <= cand;
        end
      end else if (irq_req) begin
        irq_req <= 1'b0;
        irq_tt  <= '0;
      end
    end
  end
endmodule

module irq_level_resolver_chk #(
  parameter int LVLS = 16,
  parameter int PIL_W = 4,
  parameter int TT_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic [LVLS-1:0]  ext_lvl,
  input logic [LVLS-1:0]  soft_int,
  input logic [PIL_W-1:0] cur_pil,
  input logic             int_en,
  input logic             vec_pend,
  input logic             irq_req,
  input logic [TT_W-1:0]  irq_tt
);
  logic rst_seen;
  logic [LVLS:0] pend_chk;
  always_ff @(posedge clk) rst_seen <= rst;

  assign pend_chk = {1'b0, ext_lvl | (soft_int & 16'h7FFE)}
                  | ((soft_int[0] | soft_int[15]) ? 17'h04000 : 17'h0);

  // R1
  always_ff @(posedge clk)
    if (rst_seen && !rst) reset_clear_chk: assert (!irq_req && irq_tt == '0);

  // R4
  vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    vec_pend |=> ($stable(irq_req) && $stable(irq_tt)));

  // R5
  below_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!vec_pend && (pend_chk < (17'd2 << cur_pil))) |=> (!irq_req && irq_tt == '0));

  // R9
  disable_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (!vec_pend && !int_en && irq_req) |=> !irq_req);

  // R6
  tt_form_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_tt[8:4] == 5'h04 && irq_tt[3:0] != 4'h0));

  // R6
  req_tt_pair_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req == (irq_tt != '0));
endmodule

bind irq_level_resolver irq_level_resolver_chk #(.LVLS(LVLS), .PIL_W(PIL_W), .TT_W(TT_W)) u_chk (
  .clk(clk), .rst(rst), .ext_lvl(ext_lvl), .soft_int(soft_int), .cur_pil(cur_pil),
  .int_en(int_en), .vec_pend(vec_pend), .irq_req(irq_req), .irq_tt(irq_tt));

// File: tb/test_irq_level_resolver.sv
module test_irq_level_resolver;
  logic clk = 0, rst = 1;
  logic [15:0] ext_lvl = 0, soft_int = 0;
  logic [3:0] cur_pil = 0;
  logic int_en = 0, vec_pend = 0;
  logic [2:0] trap_lvl = 0;
  logic [8:0] tt_busy = 0;
  logic irq_req;
  logic [8:0] irq_tt;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  irq_level_resolver i_irq_level_resolver (
    .clk(clk), .rst(rst), .ext_lvl(ext_lvl), .soft_int(soft_int), .cur_pil(cur_pil),
    .int_en(int_en), .trap_lvl(trap_lvl), .tt_busy(tt_busy), .vec_pend(vec_pend),
    .irq_req(irq_req), .irq_tt(irq_tt));

  // ext, soft, pil, ie, tl, tt_busy, vp | exp req, exp tt
  localparam int NV = 20;
  localparam logic [59:0] VEC [NV] = '{
    {16'h0020, 16'h0000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b0, 1'b1, 9'h045}, // R6
    {16'h0220, 16'h0000, 4'd3,  1'b1, 3'd0, 9'h000, 1'b0, 1'b1, 9'h049}, // R6
    {16'h0220, 16'h0000, 4'd3,  1'b1, 3'd0, 9'h000, 1'b0, 1'b1, 9'h049}, // R8
    {16'h0000, 16'h0001, 4'd3,  1'b1, 3'd0, 9'h000, 1'b0, 1'b1, 9'h04E}, // R3
    {16'h0000, 16'h8000, 4'd3,  1'b1, 3'd0, 9'h000, 1'b0, 1'b1, 9'h04E}, // R3
    {16'h0000, 16'h0402, 4'd0,  1'b1, 3'd0, 9'h000, 1'b0, 1'b1, 9'h04A}, // R2
    {16'h0004, 16'h8001, 4'd0,  1'b1, 3'd0, 9'h000, 1'b0, 1'b1, 9'h04E}, // R2
    {16'h8000, 16'h0000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b1, 1'b1, 9'h04E}, // R4
    {16'h0010, 16'h0000, 4'd4,  1'b1, 3'd0, 9'h000, 1'b0, 1'b0, 9'h000}, // R5
    {16'h8000, 16'h0000, 4'd15, 1'b1, 3'd0, 9'h000, 1'b0, 1'b0, 9'h000}, // R5
    {16'h0100, 16'h0000, 4'd2,  1'b0, 3'd0, 9'h000, 1'b0, 1'b0, 9'h000}, // R9
    {16'h0100, 16'h0000, 4'd2,  1'b1, 3'd0, 9'h000, 1'b0, 1'b1, 9'h048}, // R6
    {16'h0100, 16'h0000, 4'd2,  1'b0, 3'd0, 9'h000, 1'b0, 1'b0, 9'h000}, // R9
    {16'h0100, 16'h0000, 4'd2,  1'b1, 3'd1, 9'h04C, 1'b0, 1'b0, 9'h000}, // R7
    {16'h0100, 16'h0000, 4'd2,  1'b1, 3'd1, 9'h047, 1'b0, 1'b1, 9'h048}, // R7
    {16'h0200, 16'h0000, 4'd2,  1'b1, 3'd0, 9'h04C, 1'b0, 1'b1, 9'h049}, // R7
    {16'h0020, 16'h0000, 4'd0,  1'b1, 3'd1, 9'h07F, 1'b0, 1'b1, 9'h045}, // R7
    {16'h0800, 16'h0000, 4'd0,  1'b1, 3'd1, 9'h04C, 1'b0, 1'b1, 9'h045}, // R7
    {16'h0800, 16'h0000, 4'd0,  1'b0, 3'd0, 9'h000, 1'b1, 1'b1, 9'h045}, // R4
    {16'h0060, 16'h0000, 4'd5,  1'b1, 3'd0, 9'h000, 1'b0, 1'b1, 9'h046}  // R5
  };

  task automatic chk(input string req, input logic er, input logic [8:0] et);
    n_chk++;
    if (irq_req !== er || irq_tt !== et) begin
      n_bad++;
      $display("FAIL %s: got req=%0b tt=%03h, expected req=%0b tt=%03h", req, irq_req, irq_tt, er, et);
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 1'b0, 9'h000);
    rst = 0;
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      {ext_lvl, soft_int, cur_pil, int_en, trap_lvl, tt_busy, vec_pend} = VEC[k][59:10];
      @(negedge clk);
      chk($sformatf("R2-R9 vector %0d", k), VEC[k][9], VEC[k][8:0]);
    end
    vec_pend = 0; int_en = 1; trap_lvl = 0; cur_pil = 0; ext_lvl = 16'h0400; soft_int = 0;
    @(negedge clk);
    chk("R6", 1'b1, 9'h04A);
    rst = 1;
    @(negedge clk);
    chk("R1", 1'b0, 9'h000);
    rst = 0;
    @(negedge clk);
    chk("R6", 1'b1, 9'h04A);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule